// File: doc/BRIEF.md
# Bus Wait-State and Ready Sequencer

This block sets the length of every external bus access. A requester presents a region index that has already been decoded. The requester can be the processor or a DMA engine, and the timing depends only on the index, not on who made the request. The sequencer then steps through the base phases T1, T2, T3 and T4, and places wait phases between T3 and T4.

Each region supplies a wait-state code and a flag that says whether external ready is required. Some regions use a plain two-bit wait count. A group of peripheral regions uses a three-bit code whose upper half stretches further, in a nonlinear way. One region stands for on-chip memory: it never waits and never looks at ready.

Ready can arrive on an asynchronous pin or on a synchronous pin. Each pin goes through its own capture flops, and the two results are merged into a single internal ready. The programmed waits always run out before ready can end an access. If ready is missing at the first sample, the access is held until ready is seen and then receives one trailing wait.

Top module: `wait_sequencer`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle (`busState` = 0) with `accessDone` low, even in the middle of an access.
- R2: `busState` uses these codes: idle=0, T1=1, T2=2, T3=3, wait=4, T4=5. An `accessReq` seen while idle gives T1, T2 and T3 on the next three cycles. Zero or more wait cycles follow, then T4, then idle.
- R3: `accessDone` is high exactly in the T4 cycle, which lasts one cycle.
- R4: Regions 1 to 3 use the two-bit code in bits [1:0] of their field, giving 0 to 3 waits; bit 2 is ignored. Region r's code is `waitCodes[3r+2:3r]` and its ready flag is `readyReq[r]`.
- R5: Regions 4 to 7 use all three bits. Codes 0 to 3 give 0 to 3 waits, and codes 4, 5, 6 and 7 give 5, 7, 9 and 15 waits.
- R6: Region 0 (internal memory) always takes zero waits and ignores both the ready inputs and its configuration.
- R7: With the ready flag clear, the number of waits equals the programmed count N, whatever the ready inputs do.
- R8: With the ready flag set and N≥1, ready is sampled in the first wait cycle. If it is seen there, exactly N waits are inserted.
- R9: With the ready flag set and N≥1, if ready is absent in the first wait, waiting continues until ready is first seen in wait j. The wait count is then max(N, j+1).
- R10: With the ready flag set and N=0, ready is sampled in T3. If it is seen there, T4 follows directly. Otherwise ready first seen in wait j gives j+1 waits.
- R11: The synchronous ready counts in the same cycle it is presented, because it is captured on the falling edge. The asynchronous ready goes through a rising-edge flop and then a falling-edge flop, so it counts one cycle later. Either one alone suffices.
- R12: An `accessReq` that arrives while an access is in progress is ignored. The current access keeps its timing, and idle follows T4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| accessReq | input | 1 | Start of an access, taken only while idle |
| regionIdx | input | 3 | Decoded region index of the access |
| waitCodes | input | 24 | Three-bit wait code per region, region r at bits [3r+2:3r] |
| readyReq | input | 8 | Per-region flag: external ready required |
| asyncRdy | input | 1 | Asynchronous external ready |
| syncRdy | input | 1 | Synchronous external ready |
| busState | output | 3 | Current bus phase code |
| accessDone | output | 1 | High for the single T4 cycle |

## Verification
The bench sweeps every region against every code, with ready ignored and with ready required. For each case it presents synchronous ready starting at wait index 0 through 4. This separates the two-bit mapping, the three-bit mapping and the internal override. It also separates the on-time ready case from the stretched case and checks that the trailing wait is added only after a late ready. Separate runs drive only the asynchronous pin, which shows its extra cycle of latency. Other runs inject a request in the middle of an access and a reset in the middle of an access.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } busPhase_e;

  // control -> datapath
  typedef struct packed {
    logic load;   // latch region timing at access start
    logic arm;    // T3: load wait counter and ready flags
    logic step;   // wait cycle: advance counter and ready tracking
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic t3Exit; // leave T3 straight to T4
    logic twExit; // leave the wait phase to T4
  } seqStatus_t;

endpackage

// File: rtl/wsq_datapath.sv
module wsq_datapath
  import wsq_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter logic [NUM_REGIONS-1:0] WIDE_MASK = 8'hF0,
  parameter int INTERNAL_REGION = 0,
  localparam int IDX_W = $clog2(NUM_REGIONS),
  localparam int MAX_WAITS = 15,
  localparam int CNT_W = $clog2(MAX_WAITS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seqStrobe_t               strobe,
  input  logic [IDX_W-1:0]         regionIdx,
  input  logic [NUM_REGIONS*3-1:0] waitCodes,
  input  logic [NUM_REGIONS-1:0]   readyReq,
  input  logic                     asyncRdy,
  input  logic                     syncRdy,
  output seqStatus_t               status
);

  function automatic logic [3:0] wideMap(input logic [2:0] code);
    case (code)
      3'd4:    wideMap = 4'd5;
      3'd5:    wideMap = 4'd7;
      3'd6:    wideMap = 4'd9;
      3'd7:    wideMap = 4'd15;
      default: wideMap = {1'b0, code};
    endcase
  endfunction

  // per-region decode of wait count and ready need
  logic [CNT_W-1:0]       regWaits [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] regNeedRdy;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    logic [2:0] code;
    assign code = waitCodes[3*r +: 3];
    if (r == INTERNAL_REGION) begin : g_int
      logic unusedInt;
      assign unusedInt     = ^{code, readyReq[r]};
      assign regWaits[r]   = '0;
      assign regNeedRdy[r] = 1'b0;
    end else if (WIDE_MASK[r]) begin : g_wide
      assign regWaits[r]   = CNT_W'(wideMap(code));
      assign regNeedRdy[r] = readyReq[r];
    end else begin : g_narrow
      logic unusedHi;
      assign unusedHi      = code[2];
      assign regWaits[r]   = CNT_W'(code[1:0]);
      assign regNeedRdy[r] = readyReq[r];
    end
  end

  // ready capture: async rise then fall, sync on fall
  logic asyncRise, asyncFall, syncFall, busReady;

  always_ff @(posedge clk) begin
    if (rst) asyncRise <= 1'b0;
    else     asyncRise <= asyncRdy;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      asyncFall <= 1'b0;
      syncFall  <= 1'b0;
    end else begin
      asyncFall <= asyncRise;
      syncFall  <= syncRdy;
    end
  end

  assign busReady = asyncFall | syncFall;

  // access timing state
  logic [CNT_W-1:0] waitsQ, remQ, remDec, remNext;
  logic             needRdyQ, firstQ, rdyDoneQ, rdyDoneNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      waitsQ   <= '0;
      needRdyQ <= 1'b0;
      remQ     <= '0;
      firstQ   <= 1'b0;
      rdyDoneQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        waitsQ   <= regWaits[regionIdx];
        needRdyQ <= regNeedRdy[regionIdx];
      end
      if (strobe.arm) begin
        remQ     <= waitsQ;
        firstQ   <= (waitsQ != '0);
        rdyDoneQ <= !needRdyQ;
      end else if (strobe.step) begin
        remQ     <= remNext;
        firstQ   <= 1'b0;
        rdyDoneQ <= rdyDoneNext;
      end
    end
  end

  always_comb begin
    remDec      = (remQ == '0) ? '0 : remQ - 1'b1;
    remNext     = remDec;
    rdyDoneNext = rdyDoneQ;
    if (!rdyDoneQ && busReady) begin
      rdyDoneNext = 1'b1;
      // late ready: one trailing wait after it is seen
      if (!firstQ && remDec == '0) remNext = CNT_W'(1);
    end
  end

  assign status.twExit = rdyDoneNext && (remNext == '0);
  assign status.t3Exit = (waitsQ == '0) && (!needRdyQ || busReady);

  // R8: programmed waits still pending keep the access in the wait phase
  a_r8_programmed_first: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && remQ > CNT_W'(1)) |=> strobe.step);

  // R9: a wait without ready seen is followed by another wait
  a_r9_stretch_no_ready: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !rdyDoneQ && !busReady) |=> strobe.step);

  // R6: internal region latches zero waits and no ready need
  a_r6_internal_zero: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && regionIdx == IDX_W'(INTERNAL_REGION)) |=> (waitsQ == '0 && !needRdyQ));

endmodule

// File: rtl/wsq_control.sv
module wsq_control
  import wsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accessReq,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic [2:0] busState,
  output logic       accessDone
);

  busPhase_e phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: if (accessReq) begin
        strobe.load = 1'b1;
        phaseNext   = PH_T1;
      end
      PH_T1: phaseNext = PH_T2;
      PH_T2: phaseNext = PH_T3;
      PH_T3: begin
        strobe.arm = 1'b1;
        phaseNext  = status.t3Exit ? PH_T4 : PH_TW;
      end
      PH_TW: begin
        strobe.step = 1'b1;
        if (status.twExit) phaseNext = PH_T4;
      end
      PH_T4:   phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign busState   = phase;
  assign accessDone = (phase == PH_T4);

  // R1: reset brings the sequencer to idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (busState == 3'd0 && !accessDone));

  // R2: base phases follow in order
  a_r2_t1_to_t2: assert property (@(posedge clk) disable iff (rst)
    (busState == 3'd1) |=> (busState == 3'd2));
  a_r2_t2_to_t3: assert property (@(posedge clk) disable iff (rst)
    (busState == 3'd2) |=> (busState == 3'd3));

  // R3: done lasts a single cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    accessDone |=> !accessDone);

  // R12: a request during an access never restarts T1
  a_r12_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busState != 3'd0 && accessReq) |=> (busState != 3'd1));

endmodule

// File: rtl/wait_sequencer.sv
module wait_sequencer
  import wsq_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter logic [NUM_REGIONS-1:0] WIDE_MASK = 8'hF0,
  parameter int INTERNAL_REGION = 0,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accessReq,
  input  logic [IDX_W-1:0]         regionIdx,
  input  logic [NUM_REGIONS*3-1:0] waitCodes,
  input  logic [NUM_REGIONS-1:0]   readyReq,
  input  logic                     asyncRdy,
  input  logic                     syncRdy,
  output logic [2:0]               busState,
  output logic                     accessDone
);

  seqStrobe_t strobe;
  seqStatus_t status;

  wsq_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .accessReq  (accessReq),
    .status     (status),
    .strobe     (strobe),
    .busState   (busState),
    .accessDone (accessDone)
  );

  wsq_datapath #(
    .NUM_REGIONS     (NUM_REGIONS),
    .WIDE_MASK       (WIDE_MASK),
    .INTERNAL_REGION (INTERNAL_REGION)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .regionIdx (regionIdx),
    .waitCodes (waitCodes),
    .readyReq  (readyReq),
    .asyncRdy  (asyncRdy),
    .syncRdy   (syncRdy),
    .status    (status)
  );

endmodule

// File: tb/sim_wait_sequencer.sv
module sim_wait_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accessReq = 1'b0;
  logic [2:0]  regionIdx = '0;
  logic [23:0] waitCodes = '0;
  logic [7:0]  readyReq = '0;
  logic        asyncRdy = 1'b0;
  logic        syncRdy = 1'b0;
  logic [2:0]  busState;
  logic        accessDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wait_sequencer u0 (
    .clk        (clk),
    .rst        (rst),
    .accessReq  (accessReq),
    .regionIdx  (regionIdx),
    .waitCodes  (waitCodes),
    .readyReq   (readyReq),
    .asyncRdy   (asyncRdy),
    .syncRdy    (syncRdy),
    .busState   (busState),
    .accessDone (accessDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int progWaits(input int region, input int code);
    if (region == 0) return 0;
    if (region >= 4) begin
      case (code)
        4: return 5;
        5: return 7;
        6: return 9;
        7: return 15;
        default: return code;
      endcase
    end
    return code & 3;
  endfunction

  function automatic int expWaits(input int region, input int code, input bit rq, input int d);
    int n;
    int s;
    n = progWaits(region, code);
    if (!rq || region == 0) return n;
    s = (n == 0) ? 0 : 1;
    if (d <= s) return n;
    return (n > d + 1) ? n : d + 1;
  endfunction

  function automatic string tagFor(input int region, input int code, input bit rq, input int d);
    int n;
    n = progWaits(region, code);
    if (region == 0) return "R6";
    if (!rq) return (region >= 4) ? "R5" : "R4";
    if (n == 0) return "R10";
    return (d <= 1) ? "R8" : "R9";
  endfunction

  // one access; ready first effective from index d (T3 = 0, wait k = k)
  task automatic runAccess(input int region, input int code, input bit rq, input int d,
                           input bit useAsync, input bit inject, input string tag);
    int cyc;
    int waits;
    int idx;
    bit seqOk;
    bit doneOk;
    int ph;
    int exp;
    waitCodes = {8{code[2:0]}};
    readyReq  = {8{rq}};
    @(posedge clk); #1;
    accessReq = 1'b1;
    regionIdx = region[2:0];
    @(posedge clk); #1;
    accessReq = 1'b0;
    cyc = 0; waits = 0; idx = -1; seqOk = 1; doneOk = 1;
    ph = int'(busState);
    while (ph != 5 && cyc < 60) begin
      if (accessDone) doneOk = 0;
      if (cyc < 3 && ph != cyc + 1) seqOk = 0;
      if (cyc >= 3 && ph != 4) seqOk = 0;
      if (ph == 3) idx = 0;
      if (ph == 4) begin waits++; idx = waits; end
      syncRdy  = !useAsync && (ph == 3 || ph == 4) && idx >= d;
      asyncRdy = useAsync && (ph == 3 || ph == 4) && idx + 1 >= d;
      accessReq = inject && cyc == 1;
      regionIdx = inject && cyc == 1 ? 3'd7 : region[2:0];
      @(posedge clk); #1;
      cyc++;
      ph = int'(busState);
    end
    accessReq = 1'b0;
    syncRdy = 1'b0;
    asyncRdy = 1'b0;
    exp = expWaits(region, code, rq, d);
    check(ph == 5 && waits == exp, tag, waits, exp);
    check(seqOk && ph == 5, "R2", ph, 5);
    check(doneOk && accessDone, "R3", int'(accessDone), 1);
    @(posedge clk); #1;
    check(busState == 3'd0 && !accessDone, inject ? "R12" : "R2", int'(busState), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busState == 3'd0 && !accessDone, "R1", int'(busState), 0);
    rst = 1'b0;

    // full sweep with synchronous ready: R4 R5 R6 R7 R8 R9 R10
    for (int region = 0; region < 8; region++)
      for (int code = 0; code < 8; code++)
        for (int rq = 0; rq < 2; rq++)
          for (int d = 0; d < 5; d++)
            runAccess(region, code, rq[0], d, 1'b0, 1'b0, tagFor(region, code, rq[0], d));

    // R11: asynchronous ready path, one cycle later than sync
    for (int code = 0; code < 8; code++)
      for (int d = 1; d < 5; d++)
        runAccess(5, code, 1'b1, d, 1'b1, 1'b0, "R11");

    // R12: request injected mid-access
    for (int code = 0; code < 8; code++)
      runAccess(6, code, 1'b0, 0, 1'b0, 1'b1, "R12");

    // R1: reset in the middle of an access
    waitCodes = {8{3'd7}};
    readyReq = '0;
    @(posedge clk); #1;
    accessReq = 1'b1;
    regionIdx = 3'd4;
    @(posedge clk); #1;
    accessReq = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check(busState == 3'd4, "R5", int'(busState), 4);
    rst = 1'b1;
    @(posedge clk); #1;
    check(busState == 3'd0 && !accessDone, "R1", int'(busState), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(busState == 3'd0, "R1", int'(busState), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule